// File: doc/BRIEF.md
# PLL Frequency Ramp Sequencer

This block raises the core clock of a chain of hashing chips in stages instead of one jump, so that the supply does not sag under a sudden rise in current. When a start request arrives with a target frequency in MHz, the sequencer produces an ordered series of PLL configuration writes addressed to every chip at once. Each write is handed to a frame transmitter over a valid/ready handshake. After each write the sequencer waits out a settle interval before it offers the next one.

Each write carries a feedback-divider value derived from a 25 MHz reference with unity reference and post dividers. It also carries the post-divider fields in one of two encodings, chosen by a mode input: the raw divider, or the divider less one. Fixed intermediate stages come first, and any stage that is not below the target is dropped. The target write comes last and is followed by a longer settle. After that a done flag is raised and held until the next ramp is accepted.

Top module: `pll_ramp_seq`

## Requirements
- R1: While reset is asserted and after it is released with no start, `wr_valid_o`, `busy_o` and `done_o` are all low.
- R2: A ramp offers the intermediate frequencies 200, 300 and 400 MHz in rising order, each only when it is strictly below the rounded target, then the rounded target itself; `wr_last_o` is high only on that final write.
- R3: The target is rounded down to a multiple of 25 MHz, and every write carries `wr_fbdiv_o` = frequency / 25 (200 gives 8, 300 gives 12, 400 gives 16, 500 gives 20); the FBDIV values within one ramp strictly increase.
- R4: `wr_refdiv_o` is always 1; both post-divider fields encode a unity divider as 0 when `minus_one_i` was high at start and as 1 when it was low.
- R5: Every write carries chip address 0 (broadcast) on `wr_addr_o`.
- R6: After the handshake of an intermediate write, `wr_valid_o` is low for exactly SETTLE_STEP_CYC cycles and then rises with the next write.
- R7: After the handshake of the final write, `done_o` rises exactly SETTLE_FINAL_CYC cycles later and `busy_o` falls in the same cycle.
- R8: A start request while `busy_o` is high is ignored: the running ramp continues unchanged and no new ramp follows it.
- R9: While `wr_valid_o` is high and `wr_ready_i` is low, the write stays offered and its fields do not change.
- R10: `done_o` stays high until a new start is accepted and drops in the cycle after that start; `done_o` and `busy_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to begin a ramp (taken when not busy) |
| target_mhz_i | input | FREQ_W | Target core frequency in MHz |
| minus_one_i | input | 1 | Post-divider encoding: 1 = divider minus one, 0 = raw |
| wr_valid_o | output | 1 | A PLL write is offered |
| wr_ready_i | input | 1 | Transmitter takes the offered write |
| wr_addr_o | output | ADDR_W | Chip address of the write (broadcast) |
| wr_fbdiv_o | output | FB_W | Feedback-divider field |
| wr_refdiv_o | output | PD_W | Reference-divider field |
| wr_postdiv1_o | output | PD_W | First post-divider field |
| wr_postdiv2_o | output | PD_W | Second post-divider field |
| wr_last_o | output | 1 | Marks the final write of the ramp |
| busy_o | output | 1 | A ramp is in progress |
| done_o | output | 1 | The last ramp has completed its final settle |

## Verification
The first write is offered in the cycle after the clock edge that samples the start request, and each handshake drops `wr_valid_o` in the following cycle. The next write returns SETTLE_STEP_CYC edges after an intermediate handshake, and `done_o` rises SETTLE_FINAL_CYC edges after the final one. The bench drives inputs one nanosecond after each rising edge and compares every output at the falling edge against a behavioural model. That model advances on the same rising edges and keeps its own queue of expected frequencies, so each result is checked in exactly the cycle it is due, including under random back-pressure.

// File: rtl/pll_ramp_pkg.sv
package pll_ramp_pkg;

  // Number of fixed intermediate stages before the target write
  localparam int unsigned NUM_STEPS = 3;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ISSUE  = 2'd1,
    ST_SETTLE = 2'd2,
    ST_DONE   = 2'd3
  } ramp_state_e;

  // Intermediate stage frequency in MHz: 200, 300, 400
  function automatic int unsigned step_mhz(int unsigned idx);
    return 100 * (idx + 2);
  endfunction

  // Largest multiple of the reference not above f
  function automatic int unsigned round_to_ref(int unsigned f, int unsigned ref_mhz);
    return (f / ref_mhz) * ref_mhz;
  endfunction

  // Feedback divider for unity reference and post dividers
  function automatic int unsigned fbdiv_for(int unsigned f, int unsigned ref_mhz);
    return f / ref_mhz;
  endfunction

  // Field encoding of a divider value
  function automatic int unsigned div_field(int unsigned div, logic minus_one);
    return minus_one ? (div - 1) : div;
  endfunction

endpackage

// File: rtl/pll_ramp_slot_pick.sv
// Finds the first stage at or after from_i whose frequency lies strictly
// below the target; returns NUM_STEPS (the target slot) when none does.
module pll_ramp_slot_pick
  import pll_ramp_pkg::*;
#(
  parameter int unsigned FREQ_W = 11,
  parameter int unsigned SLOT_W = 2
) (
  input  logic [FREQ_W-1:0] tgt_i,
  input  logic [SLOT_W-1:0] from_i,
  output logic [SLOT_W-1:0] slot_o
);

  logic [NUM_STEPS-1:0] eligible;

  for (genvar g = 0; g < NUM_STEPS; g++) begin : g_elig
    assign eligible[g] = (step_mhz(g) < 32'(tgt_i)) && (from_i <= SLOT_W'(g));
  end

  always_comb begin
    slot_o = SLOT_W'(NUM_STEPS);
    for (int i = NUM_STEPS - 1; i >= 0; i--) begin
      if (eligible[i]) slot_o = SLOT_W'(i);
    end
  end

endmodule

// File: rtl/pll_ramp_field_enc.sv
// Builds the register fields of the write for the current slot.
module pll_ramp_field_enc
  import pll_ramp_pkg::*;
#(
  parameter int unsigned FREQ_W  = 11,
  parameter int unsigned SLOT_W  = 2,
  parameter int unsigned FB_W    = 8,
  parameter int unsigned PD_W    = 3,
  parameter int unsigned REF_MHZ = 25
) (
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [FREQ_W-1:0] tgt_i,
  input  logic              minus_one_i,
  output logic [FB_W-1:0]   fbdiv_o,
  output logic [PD_W-1:0]   refdiv_o,
  output logic [PD_W-1:0]   postdiv1_o,
  output logic [PD_W-1:0]   postdiv2_o,
  output logic              last_o
);

  localparam int unsigned UNITY_DIV = 1;

  logic [31:0] slot_freq;

  assign last_o    = (slot_i == SLOT_W'(NUM_STEPS));
  assign slot_freq = last_o ? 32'(tgt_i) : step_mhz(32'(slot_i));

  assign fbdiv_o    = FB_W'(fbdiv_for(slot_freq, REF_MHZ));
  assign refdiv_o   = PD_W'(UNITY_DIV);
  assign postdiv1_o = PD_W'(div_field(UNITY_DIV, minus_one_i));
  assign postdiv2_o = PD_W'(div_field(UNITY_DIV, minus_one_i));

endmodule

// File: rtl/pll_ramp_settle_tmr.sv
// Down-counter: after load with value N, expire_o is high in the Nth cycle.
module pll_ramp_settle_tmr #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             expire_o
);

  logic [CNT_W-1:0] cnt_q;
  logic             run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (load_i) begin
      cnt_q <= len_i - CNT_W'(1);
      run_q <= 1'b1;
    end else if (run_q) begin
      if (cnt_q == '0) run_q <= 1'b0;
      else             cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign expire_o = run_q && (cnt_q == '0);

endmodule

// File: rtl/pll_ramp_seq.sv
module pll_ramp_seq
  import pll_ramp_pkg::*;
#(
  parameter int unsigned FREQ_W           = 11,
  parameter int unsigned FB_W             = 8,
  parameter int unsigned PD_W             = 3,
  parameter int unsigned ADDR_W           = 16,
  parameter int unsigned BCAST_ADDR       = 0,
  parameter int unsigned REF_MHZ          = 25,
  parameter int unsigned SETTLE_STEP_CYC  = 2000000,
  parameter int unsigned SETTLE_FINAL_CYC = 4000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [FREQ_W-1:0] target_mhz_i,
  input  logic              minus_one_i,
  output logic              wr_valid_o,
  input  logic              wr_ready_i,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [FB_W-1:0]   wr_fbdiv_o,
  output logic [PD_W-1:0]   wr_refdiv_o,
  output logic [PD_W-1:0]   wr_postdiv1_o,
  output logic [PD_W-1:0]   wr_postdiv2_o,
  output logic              wr_last_o,
  output logic              busy_o,
  output logic              done_o
);

  localparam int unsigned SLOT_W  = $clog2(NUM_STEPS + 1);
  localparam int unsigned MAX_SET = (SETTLE_STEP_CYC > SETTLE_FINAL_CYC) ?
                                    SETTLE_STEP_CYC : SETTLE_FINAL_CYC;
  localparam int unsigned CNT_W   = $clog2(MAX_SET + 1);

  ramp_state_e       state_q;
  logic [FREQ_W-1:0] tgt_q;
  logic              mode_q;
  logic [SLOT_W-1:0] slot_q;
  logic              final_q;

  // Named internal events
  logic              ramp_accept;
  logic              wr_fire;
  logic              settle_expire;
  logic [FREQ_W-1:0] tgt_round;
  logic [SLOT_W-1:0] start_slot;
  logic [SLOT_W-1:0] next_slot;
  logic [CNT_W-1:0]  settle_len;

  assign ramp_accept = start_i && ((state_q == ST_IDLE) || (state_q == ST_DONE));
  assign wr_valid_o  = (state_q == ST_ISSUE);
  assign wr_fire     = wr_valid_o && wr_ready_i;
  assign tgt_round   = FREQ_W'(round_to_ref(32'(target_mhz_i), REF_MHZ));
  assign settle_len  = wr_last_o ? CNT_W'(SETTLE_FINAL_CYC) : CNT_W'(SETTLE_STEP_CYC);

  pll_ramp_slot_pick #(.FREQ_W(FREQ_W), .SLOT_W(SLOT_W)) u_pick_first (
    .tgt_i  (tgt_round),
    .from_i ('0),
    .slot_o (start_slot)
  );

  pll_ramp_slot_pick #(.FREQ_W(FREQ_W), .SLOT_W(SLOT_W)) u_pick_next (
    .tgt_i  (tgt_q),
    .from_i (slot_q + SLOT_W'(1)),
    .slot_o (next_slot)
  );

  pll_ramp_field_enc #(
    .FREQ_W(FREQ_W), .SLOT_W(SLOT_W), .FB_W(FB_W), .PD_W(PD_W), .REF_MHZ(REF_MHZ)
  ) u_enc (
    .slot_i      (slot_q),
    .tgt_i       (tgt_q),
    .minus_one_i (mode_q),
    .fbdiv_o     (wr_fbdiv_o),
    .refdiv_o    (wr_refdiv_o),
    .postdiv1_o  (wr_postdiv1_o),
    .postdiv2_o  (wr_postdiv2_o),
    .last_o      (wr_last_o)
  );

  pll_ramp_settle_tmr #(.CNT_W(CNT_W)) u_settle (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (wr_fire),
    .len_i    (settle_len),
    .expire_o (settle_expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      tgt_q   <= '0;
      mode_q  <= 1'b0;
      slot_q  <= '0;
      final_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE, ST_DONE: begin
          if (ramp_accept) begin
            tgt_q   <= tgt_round;
            mode_q  <= minus_one_i;
            slot_q  <= start_slot;
            final_q <= 1'b0;
            state_q <= ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          if (wr_fire) begin
            final_q <= wr_last_o;
            if (!wr_last_o) slot_q <= next_slot;
            state_q <= ST_SETTLE;
          end
        end
        ST_SETTLE: begin
          if (settle_expire) state_q <= final_q ? ST_DONE : ST_ISSUE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign wr_addr_o = ADDR_W'(BCAST_ADDR);
  assign busy_o    = (state_q == ST_ISSUE) || (state_q == ST_SETTLE);
  assign done_o    = (state_q == ST_DONE);

endmodule

// File: rtl/pll_ramp_seq_chk.sv
module pll_ramp_seq_chk #(
  parameter int unsigned FB_W             = 8,
  parameter int unsigned PD_W             = 3,
  parameter int unsigned ADDR_W           = 16,
  parameter int unsigned BCAST_ADDR       = 0,
  parameter int unsigned SETTLE_STEP_CYC  = 2000000,
  parameter int unsigned SETTLE_FINAL_CYC = 4000000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              wr_valid_o,
  input logic              wr_ready_i,
  input logic [ADDR_W-1:0] wr_addr_o,
  input logic [FB_W-1:0]   wr_fbdiv_o,
  input logic [PD_W-1:0]   wr_refdiv_o,
  input logic [PD_W-1:0]   wr_postdiv1_o,
  input logic [PD_W-1:0]   wr_postdiv2_o,
  input logic              wr_last_o,
  input logic              wr_fire,
  input logic              ramp_accept
);

  logic [FB_W-1:0] prev_fb;
  logic            prev_ok;
  logic            last_seen;
  logic [31:0]     quiet_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_fb   <= '0;
      prev_ok   <= 1'b0;
      last_seen <= 1'b0;
      quiet_cnt <= '0;
    end else begin
      if (ramp_accept) begin
        prev_ok   <= 1'b0;
        last_seen <= 1'b0;
      end else if (wr_fire) begin
        prev_fb   <= wr_fbdiv_o;
        prev_ok   <= 1'b1;
        last_seen <= wr_last_o;
      end
      if (wr_fire)               quiet_cnt <= '0;
      else if (quiet_cnt != '1)  quiet_cnt <= quiet_cnt + 32'd1;
    end
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !wr_valid_o);

  p_rising_fb_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && prev_ok) |-> (wr_fbdiv_o > prev_fb));

  p_unity_fields_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o |-> (wr_refdiv_o == PD_W'(1)) && (wr_postdiv1_o == wr_postdiv2_o)
                   && (wr_postdiv1_o <= PD_W'(1)));

  p_bcast_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o |-> (wr_addr_o == ADDR_W'(BCAST_ADDR)));

  p_drop_after_fire_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> !wr_valid_o);

  p_step_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(wr_valid_o) && prev_ok) |-> (quiet_cnt == SETTLE_STEP_CYC));

  p_final_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> (last_seen && quiet_cnt == SETTLE_FINAL_CYC));

  p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && busy_o) |-> !ramp_accept);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_o && !wr_ready_i) |=> (wr_valid_o && $stable(wr_fbdiv_o)
                                     && $stable(wr_last_o) && $stable(wr_postdiv1_o)));

  p_done_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && busy_o));

endmodule

bind pll_ramp_seq pll_ramp_seq_chk #(
  .FB_W(FB_W), .PD_W(PD_W), .ADDR_W(ADDR_W), .BCAST_ADDR(BCAST_ADDR),
  .SETTLE_STEP_CYC(SETTLE_STEP_CYC), .SETTLE_FINAL_CYC(SETTLE_FINAL_CYC)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .start_i       (start_i),
  .busy_o        (busy_o),
  .done_o        (done_o),
  .wr_valid_o    (wr_valid_o),
  .wr_ready_i    (wr_ready_i),
  .wr_addr_o     (wr_addr_o),
  .wr_fbdiv_o    (wr_fbdiv_o),
  .wr_refdiv_o   (wr_refdiv_o),
  .wr_postdiv1_o (wr_postdiv1_o),
  .wr_postdiv2_o (wr_postdiv2_o),
  .wr_last_o     (wr_last_o),
  .wr_fire       (wr_fire),
  .ramp_accept   (ramp_accept)
);

// File: tb/pll_ramp_seq_tb.sv
`timescale 1ns/1ps
module pll_ramp_seq_tb;

  localparam int STEP_CYC  = 12;
  localparam int FINAL_CYC = 30;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [10:0] target_mhz_i = '0;
  logic        minus_one_i = 1'b0;
  logic        wr_ready_i = 1'b1;
  logic        wr_valid_o;
  logic [15:0] wr_addr_o;
  logic [7:0]  wr_fbdiv_o;
  logic [2:0]  wr_refdiv_o, wr_postdiv1_o, wr_postdiv2_o;
  logic        wr_last_o, busy_o, done_o;

  always #2.5 clk = ~clk;

  pll_ramp_seq #(.SETTLE_STEP_CYC(STEP_CYC), .SETTLE_FINAL_CYC(FINAL_CYC)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .target_mhz_i(target_mhz_i),
    .minus_one_i(minus_one_i), .wr_valid_o(wr_valid_o), .wr_ready_i(wr_ready_i),
    .wr_addr_o(wr_addr_o), .wr_fbdiv_o(wr_fbdiv_o), .wr_refdiv_o(wr_refdiv_o),
    .wr_postdiv1_o(wr_postdiv1_o), .wr_postdiv2_o(wr_postdiv2_o),
    .wr_last_o(wr_last_o), .busy_o(busy_o), .done_o(done_o)
  );

  int n_tests = 0;
  int n_fail  = 0;
  int dut_writes = 0;
  bit stall = 1'b0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  int  m_q[$];
  int  m_cur = 0;
  int  m_gap = 0;
  bit  m_valid = 0, m_busy = 0, m_done = 0, m_last = 0, m_mode = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_q.delete();
      m_valid = 0; m_busy = 0; m_done = 0; m_last = 0; m_gap = 0;
    end else if (m_valid) begin
      if (wr_ready_i) begin
        m_valid = 0;
        m_gap = m_last ? FINAL_CYC : STEP_CYC;
      end
    end else if (m_busy) begin
      m_gap--;
      if (m_gap == 0) begin
        if (m_last) begin
          m_busy = 0; m_done = 1;
        end else begin
          m_cur = m_q.pop_front();
          m_last = (m_q.size() == 0);
          m_valid = 1;
        end
      end
    end else if (start_i) begin
      int r;
      r = (int'(target_mhz_i) / 25) * 25;
      for (int f = 200; f <= 400; f += 100) if (f < r) m_q.push_back(f);
      m_q.push_back(r);
      m_mode = minus_one_i;
      m_cur = m_q.pop_front();
      m_last = (m_q.size() == 0);
      m_valid = 1; m_busy = 1; m_done = 0;
    end
  end

  // Per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(wr_valid_o == m_valid, "R2 R6 write offer timing", int'(wr_valid_o), int'(m_valid));
      chk(busy_o == m_busy, "R7 R8 busy", int'(busy_o), int'(m_busy));
      chk(done_o == m_done, "R7 R10 done", int'(done_o), int'(m_done));
      if (m_valid && wr_valid_o) begin
        chk(int'(wr_fbdiv_o) == m_cur / 25, "R3 R9 fbdiv", int'(wr_fbdiv_o), m_cur / 25);
        chk(wr_last_o == m_last, "R2 last flag", int'(wr_last_o), int'(m_last));
        chk(wr_addr_o == 16'd0, "R5 broadcast address", int'(wr_addr_o), 0);
        chk(int'(wr_refdiv_o) == 1, "R4 refdiv", int'(wr_refdiv_o), 1);
        chk(int'(wr_postdiv1_o) == (m_mode ? 0 : 1), "R4 postdiv1",
            int'(wr_postdiv1_o), m_mode ? 0 : 1);
        chk(int'(wr_postdiv2_o) == (m_mode ? 0 : 1), "R4 postdiv2",
            int'(wr_postdiv2_o), m_mode ? 0 : 1);
      end
      if (wr_valid_o && wr_ready_i) dut_writes++;
    end
  end

  // Ready driver, 1 ns after each rising edge
  always @(posedge clk) begin
    #1;
    wr_ready_i = stall ? (($urandom % 3) != 0) : 1'b1;
  end

  task automatic pulse_start(input int tgt, input bit mode);
    @(posedge clk); #1;
    start_i = 1'b1; target_mhz_i = 11'(tgt); minus_one_i = mode;
    @(posedge clk); #1;
    start_i = 1'b0;
  endtask

  task automatic wait_done();
    do @(negedge clk); while (!done_o);
  endtask

  task automatic ramp(input int tgt, input bit mode, input bit stl, input int exp_n,
                      input string req);
    int w0;
    stall = stl;
    w0 = dut_writes;
    pulse_start(tgt, mode);
    wait_done();
    chk(dut_writes - w0 == exp_n, req, dut_writes - w0, exp_n);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!wr_valid_o && !busy_o && !done_o, "R1 outputs in reset",
        int'({wr_valid_o, busy_o, done_o}), 0);
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!wr_valid_o && !busy_o && !done_o, "R1 idle after reset",
        int'({wr_valid_o, busy_o, done_o}), 0);

    ramp(500, 1'b1, 1'b0, 4, "R2 write count for 500");
    ramp(410, 1'b0, 1'b1, 3, "R3 write count for 410 rounded to 400");
    ramp(300, 1'b1, 1'b1, 2, "R2 write count for 300");
    ramp(150, 1'b0, 1'b0, 1, "R2 write count for 150");
    ramp(200, 1'b1, 1'b0, 1, "R2 write count for 200");

    // Start while busy must be ignored
    begin
      int w0;
      stall = 1'b1;
      w0 = dutw();
      pulse_start(700, 1'b1);
      repeat (20) @(posedge clk);
      #1 start_i = 1'b1; target_mhz_i = 11'd150; minus_one_i = 1'b0;
      @(posedge clk); #1 start_i = 1'b0;
      wait_done();
      chk(dut_writes - w0 == 4, "R8 start ignored while busy", dut_writes - w0, 4);
      repeat (15) @(negedge clk);
      chk(done_o && !busy_o && !wr_valid_o, "R8 R10 no second ramp, done held",
          int'({done_o, busy_o, wr_valid_o}), 4);
    end

    ramp(825, 1'b0, 1'b1, 4, "R3 write count for 825");
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  function automatic int dutw();
    return dut_writes;
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule